// File: doc/BRIEF.md
# Nonvolatile Save/Restore Cycle Sequencer

This block sequences the timed transfers between an SRAM array and the nonvolatile shadow cells behind it. A save moves the SRAM contents into the shadow. It runs an erase phase and then a program phase. A restore moves the shadow back into the SRAM. It runs a clear phase and then a load phase, and it never alters the shadow. The array reads the phase strobes and acts on them. This block only decides which phase is active and for how long. Each phase length comes from a cycle-count input.

A transfer starts in one of two ways. A software command arrives as a one-cycle pulse with a two-bit code. A restore request can also be held pending. That request is captured whenever the supply-good input is low, and it is set by reset, so a restore always follows power-up. While any phase runs, the active-low handshake output is driven low and host access is gated off. A third command clears the autostore-enable flag. It needs no timed cycle. All pins are plain control and status lines. The command pulse has no back-pressure. A pulse that arrives when the block cannot take it is dropped, not held.

Top module: `nvs_cycle_seq`

## Requirements
- R1: While reset is asserted the block is idle, `busy_n` is 1, all four phase strobes are 0, `autostore_en` is 1, a restore request is pending, and therefore `host_en` is 0.
- R2: When the block is idle, `supply_ok` is 1 and a restore request is pending, the clear phase starts at the next clock edge and the request is consumed. This automatic restore takes priority over a command pulse in the same cycle, and that pulse is dropped.
- R3: `busy_n` is 0 in every cycle in which a phase strobe is 1, and it is 1 whenever the block is idle.
- R4: A command with code 2'b00 (save), accepted while idle, raises `ph_erase` for max(`erase_cycles`,1) cycles. It then raises `ph_program` for max(`program_cycles`,1) cycles and returns to idle.
- R5: A command with code 2'b01 (restore) raises `ph_clear` for max(`clear_cycles`,1) cycles and then `ph_load` for max(`load_cycles`,1) cycles. The automatic restore uses the same two phases.
- R6: `host_en` is 1 only when the block is idle, `supply_ok` is 1 and no restore request is pending.
- R7: A command with code 2'b10, accepted while idle, clears `autostore_en` at the next edge. `busy_n` stays 1 and no strobe is raised.
- R8: A command pulse of any code that arrives while a phase is active is ignored. The running cycle keeps its length, `autostore_en` is unchanged, and no cycle follows.
- R9: When `supply_ok` is 0 at a clock edge, any active cycle is aborted to idle and a restore request is latched. Commands are ignored while the supply is low. The automatic restore starts at the first edge after `supply_ok` returns to 1.
- R10: A command with code 2'b11 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command pulse |
| cmd_code | input | 2 | 00 save, 01 restore, 10 autostore disable, 11 none |
| supply_ok | input | 1 | Supply above the switch threshold |
| erase_cycles | input | CNT_W | Erase phase length in cycles |
| program_cycles | input | CNT_W | Program phase length in cycles |
| clear_cycles | input | CNT_W | Clear phase length in cycles |
| load_cycles | input | CNT_W | Load phase length in cycles |
| busy_n | output | 1 | Active-low handshake, low during any cycle |
| host_en | output | 1 | Host reads and writes permitted |
| ph_erase | output | 1 | Erase phase strobe |
| ph_program | output | 1 | Program phase strobe |
| ph_clear | output | 1 | SRAM clear phase strobe |
| ph_load | output | 1 | Nonvolatile-to-SRAM load phase strobe |
| autostore_en | output | 1 | Autostore enable flag |

## Verification
The assertions assume that `supply_ok`, `cmd_valid` and `cmd_code` are synchronous to `clk`. They also assume that the four length inputs change only while the block is idle, because a phase loads its length once, at entry. The stimulus drives every input on the falling edge and alters the lengths only between cycles. It sweeps the lengths from 0 to 3 for both cycle kinds. Pulses injected during busy cycles, and supply drops, are placed at the points where the ignore and abort rules apply.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_PROG  = 3'd2,
    ST_CLEAR = 3'd3,
    ST_LOAD  = 3'd4
  } nvs_state_e;

  localparam logic [1:0] CMD_SAVE    = 2'b00;
  localparam logic [1:0] CMD_RESTORE = 2'b01;
  localparam logic [1:0] CMD_ASDIS   = 2'b10;
endpackage

// File: rtl/nvs_restore_latch.sv
module nvs_restore_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic take,
  output logic pending
);
  // A low supply always wins over consumption of the request.
  always_ff @(posedge clk) begin
    if (!rst_n)          pending <= 1'b1;
    else if (!supply_ok) pending <= 1'b1;
    else if (take)       pending <= 1'b0;
  end
endmodule

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_len == '0) ? '0 : load_len - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/nvs_phase_fsm.sv
module nvs_phase_fsm
  import nvs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  input  logic             pending,
  input  logic             tmr_done,
  input  logic [CNT_W-1:0] erase_len,
  input  logic [CNT_W-1:0] program_len,
  input  logic [CNT_W-1:0] clear_len,
  input  logic [CNT_W-1:0] load_len,
  output nvs_state_e       state,
  output logic             take,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             autostore_en
);
  nvs_state_e state_n;
  logic       as_clr;

  always_comb begin
    state_n = state;
    take    = 1'b0;
    as_clr  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (supply_ok) begin
          if (pending) begin
            state_n = ST_CLEAR;
            take    = 1'b1;
          end else if (cmd_valid) begin
            case (cmd_code)
              CMD_SAVE:    state_n = ST_ERASE;
              CMD_RESTORE: state_n = ST_CLEAR;
              CMD_ASDIS:   as_clr  = 1'b1;
              default:     state_n = ST_IDLE;
            endcase
          end
        end
      end
      ST_ERASE: if (tmr_done) state_n = ST_PROG;
      ST_PROG:  if (tmr_done) state_n = ST_IDLE;
      ST_CLEAR: if (tmr_done) state_n = ST_LOAD;
      ST_LOAD:  if (tmr_done) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
    if (!supply_ok) state_n = ST_IDLE;
  end

  always_comb begin
    tmr_load = (state_n != ST_IDLE) && (state_n != state);
    case (state_n)
      ST_ERASE: tmr_len = erase_len;
      ST_PROG:  tmr_len = program_len;
      ST_CLEAR: tmr_len = clear_len;
      ST_LOAD:  tmr_len = load_len;
      default:  tmr_len = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      autostore_en <= 1'b1;
    end else begin
      state <= state_n;
      if (as_clr) autostore_en <= 1'b0;
    end
  end

  AST_AUTO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && supply_ok && pending) |=> (state == ST_CLEAR && !pending)); // R2
  AST_ERASE_TO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && tmr_done && supply_ok) |=> (state == ST_PROG)); // R4
  AST_CLEAR_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLEAR && tmr_done && supply_ok) |=> (state == ST_LOAD)); // R5
  AST_ASDIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && supply_ok && !pending && cmd_valid && cmd_code == CMD_ASDIS)
    |=> (state == ST_IDLE && !autostore_en)); // R7
  AST_BUSY_FLAG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(autostore_en)); // R8
  AST_SUPPLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (state == ST_IDLE && pending)); // R9
endmodule

// File: rtl/nvs_cycle_seq.sv
module nvs_cycle_seq
  import nvs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  input  logic             supply_ok,
  input  logic [CNT_W-1:0] erase_cycles,
  input  logic [CNT_W-1:0] program_cycles,
  input  logic [CNT_W-1:0] clear_cycles,
  input  logic [CNT_W-1:0] load_cycles,
  output logic             busy_n,
  output logic             host_en,
  output logic             ph_erase,
  output logic             ph_program,
  output logic             ph_clear,
  output logic             ph_load,
  output logic             autostore_en
);
  nvs_state_e       state;
  logic             pending;
  logic             take;
  logic             tmr_load;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_len;

  nvs_restore_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .take      (take),
    .pending   (pending)
  );

  nvs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .done     (tmr_done)
  );

  nvs_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .pending      (pending),
    .tmr_done     (tmr_done),
    .erase_len    (erase_cycles),
    .program_len  (program_cycles),
    .clear_len    (clear_cycles),
    .load_len     (load_cycles),
    .state        (state),
    .take         (take),
    .tmr_load     (tmr_load),
    .tmr_len      (tmr_len),
    .autostore_en (autostore_en)
  );

  assign ph_erase   = (state == ST_ERASE);
  assign ph_program = (state == ST_PROG);
  assign ph_clear   = (state == ST_CLEAR);
  assign ph_load    = (state == ST_LOAD);
  assign busy_n     = (state == ST_IDLE);
  assign host_en    = busy_n && supply_ok && !pending;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_erase, ph_program, ph_clear, ph_load})); // R3
  AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !host_en); // R6
  AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_program) |-> $past(ph_erase)); // R4
  AST_LOAD_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_load) |-> $past(ph_clear)); // R5
endmodule

// File: tb/nvs_cycle_seq_tb.sv
module nvs_cycle_seq_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             cmd_valid;
  logic [1:0]       cmd_code;
  logic             supply_ok;
  logic [CNT_W-1:0] erase_cycles, program_cycles, clear_cycles, load_cycles;
  logic busy_n, host_en, ph_erase, ph_program, ph_clear, ph_load, autostore_en;

  nvs_cycle_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .supply_ok(supply_ok), .erase_cycles(erase_cycles),
    .program_cycles(program_cycles), .clear_cycles(clear_cycles),
    .load_cycles(load_cycles), .busy_n(busy_n), .host_en(host_en),
    .ph_erase(ph_erase), .ph_program(ph_program), .ph_clear(ph_clear),
    .ph_load(ph_load), .autostore_en(autostore_en)
  );

  int   checks = 0;
  int   fails  = 0;
  logic as_exp = 1'b1;

  // Observed vector: busy_n, host_en, autostore_en, erase, program, clear, load
  wire [6:0] obs = {busy_n, host_en, autostore_en, ph_erase, ph_program, ph_clear, ph_load};

  localparam logic [3:0] S_NONE = 4'b0000, S_ER = 4'b1000, S_PR = 4'b0100,
                         S_CL = 4'b0010, S_LD = 4'b0001;

  function automatic logic [6:0] ex(logic bn, logic he, logic [3:0] s);
    return {bn, he, as_exp, s};
  endfunction

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive a pulse at a falling edge; returns at the next falling edge.
  task automatic pulse(logic [1:0] c);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 2'b11;
  endtask

  // Called at the falling edge of the first cycle of phase A.
  task automatic phases(logic [3:0] sa, int la_in, logic [3:0] sb, int lb_in,
                        string tag, bit inj, logic [1:0] inj_code);
    int la = (la_in == 0) ? 1 : la_in;
    int lb = (lb_in == 0) ? 1 : lb_in;
    for (int i = 0; i < la; i++) begin
      chk({tag, " R3 R6 first phase"}, obs, ex(1'b0, 1'b0, sa));
      if (i == 0 && inj) begin
        cmd_valid = 1'b1;
        cmd_code  = inj_code;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_code  = 2'b11;
    end
    for (int i = 0; i < lb; i++) begin
      chk({tag, " R3 R6 second phase"}, obs, ex(1'b0, 1'b0, sb));
      @(negedge clk);
    end
    chk({tag, " R3 R6 back to idle"}, obs, ex(1'b1, 1'b1, S_NONE));
    @(negedge clk);
    chk({tag, " R8 stays idle"}, obs, ex(1'b1, 1'b1, S_NONE));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1; cmd_valid = 1'b0; cmd_code = 2'b11;
    erase_cycles = 16'd2; program_cycles = 16'd3;
    clear_cycles = 16'd2; load_cycles = 16'd3;
    repeat (3) @(negedge clk);
    chk("R1 reset state", obs, ex(1'b1, 1'b0, S_NONE));
    rst_n = 1'b1;
    @(negedge clk);
    // R2: power-up restore starts right after reset
    phases(S_CL, 2, S_LD, 3, "R2 R5 power-up restore", 1'b0, 2'b11);

    // R2 priority: command in the same cycle as a pending request is dropped
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R9 low supply idle", obs, ex(1'b1, 1'b0, S_NONE));
    supply_ok = 1'b1;
    pulse(nvs_pkg::CMD_SAVE);
    phases(S_CL, 2, S_LD, 3, "R2 priority over command", 1'b0, 2'b11);

    for (int e = 0; e < 4; e++) begin
      for (int p = 0; p < 4; p++) begin
        erase_cycles = 16'(e); program_cycles = 16'(p);
        pulse(nvs_pkg::CMD_SAVE);
        phases(S_ER, e, S_PR, p, "R4 R8 save sweep", 1'b1, 2'((e + p) % 3));
      end
    end

    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 4; l++) begin
        clear_cycles = 16'(c); load_cycles = 16'(l);
        pulse(nvs_pkg::CMD_RESTORE);
        phases(S_CL, c, S_LD, l, "R5 R8 restore sweep", 1'b1, 2'((c + 2 * l) % 3));
      end
    end

    pulse(2'b11);
    chk("R10 reserved code no effect", obs, ex(1'b1, 1'b1, S_NONE));
    @(negedge clk);
    chk("R10 reserved code still idle", obs, ex(1'b1, 1'b1, S_NONE));

    pulse(nvs_pkg::CMD_ASDIS);
    as_exp = 1'b0;
    chk("R7 autostore disable", obs, ex(1'b1, 1'b1, S_NONE));
    @(negedge clk);
    chk("R7 no cycle after disable", obs, ex(1'b1, 1'b1, S_NONE));

    // R9: supply drop aborts a save, restore follows on recovery
    erase_cycles = 16'd3; program_cycles = 16'd2;
    clear_cycles = 16'd1; load_cycles = 16'd2;
    pulse(nvs_pkg::CMD_SAVE);
    chk("R9 save started", obs, ex(1'b0, 1'b0, S_ER));
    @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R9 aborted to idle", obs, ex(1'b1, 1'b0, S_NONE));
    pulse(nvs_pkg::CMD_SAVE);
    chk("R9 command ignored while low", obs, ex(1'b1, 1'b0, S_NONE));
    supply_ok = 1'b1;
    @(negedge clk);
    phases(S_CL, 1, S_LD, 2, "R9 restore after recovery", 1'b0, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule